// File: doc/BRIEF.md
# Block-Lock Write Permission Controller

This block sits between a serial memory's command decoder and its nonvolatile write path. For each write request it decides whether the write may proceed. A write can target one byte of a 32K x 8 array, or the single protection control register. The decision depends on three things: a volatile write-enable latch, a three-bit block-protect code that locks a region starting at address zero, and a hardware-lock enable bit. When the hardware-lock enable bit is set and the external write-protect pin is high, the protection fields are frozen.

Each request gets exactly one answer: a one-clock grant pulse or a one-clock reject pulse, in the cycle after the request. The register value is always visible on an output. Bus decoding and the array storage itself are handled by neighbouring blocks.

Top module: `blklock_guard`

## Requirements
- R1: After reset `ctrl_reg` is 8'h00 and `grant` and `reject` are low. The register layout is: bit 7 is the hardware-lock enable, bits 4:2 are the block-protect code, and bit 1 is the write-enable latch. Bits 6, 5 and 0 always read 0.
- R2: A request sampled on a clock edge produces exactly one of `grant` or `reject`, high for the single following cycle. With no request, neither is raised.
- R3: While the write-enable latch is 0, every array write is rejected. A register write that would change the block-protect code or the hardware-lock enable is also rejected.
- R4: A register write that leaves bits 7 and 4:2 equal to their current values is always granted, even with the pin high and the hardware lock set. It loads the write-enable latch from data bit 1.
- R5: Block-protect codes 0 to 7 lock these address ranges: nothing, 0-63, 0-127, 0-255, 0-511, 0-8191, 0-16383, and 0-32767. An array write inside the locked range is rejected.
- R6: An array write outside the locked range is granted while the write-enable latch is 1.
- R7: While `wp_pin` is high and the hardware-lock enable is 1, a register write that changes bits 7 or 4:2 is rejected.
- R8: While `wp_pin` is low and the latch is 1, a register write that changes bits 7 or 4:2 is granted. It loads bits 7, 4:2 and 1 from the data byte.
- R9: A rejected write leaves `ctrl_reg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, one cycle per write |
| wr_reg_sel | input | 1 | 1 = target is the protection register, 0 = array |
| wr_addr | input | 15 | Array byte address (ignored for register writes) |
| wr_data | input | 8 | Data byte of the write |
| wp_pin | input | 1 | External write-protect pin |
| grant | output | 1 | One-cycle pulse: write allowed |
| reject | output | 1 | One-cycle pulse: write refused |
| ctrl_reg | output | 8 | Current protection register value |

## Verification
A wrong limit in the region decoder shows up only at the region edges. The bench therefore probes the last locked address and the first free address for every code. An error in the latch or the frozen fields is visible on `ctrl_reg` one cycle after the offending request. A wrong decision is visible on `grant` or `reject` in that same cycle. Because of this, every scenario samples both the decision and the register value right after each request, and checks one cycle later that the pulse has dropped.

// File: rtl/blklock_pkg.sv
package blklock_pkg;
   localparam int unsigned HWEN_BIT = 7;
   localparam int unsigned BP_LSB   = 2;
   localparam int unsigned BP_W     = 3;
   localparam int unsigned WEL_BIT  = 1;

   typedef struct packed {
      logic            hwen;
      logic [BP_W-1:0] bp;
      logic            wel;
   } prot_t;

   function automatic logic [7:0] pack_reg(prot_t p);
      logic [7:0] r;
      r = '0;
      r[HWEN_BIT] = p.hwen;
      r[BP_LSB +: BP_W] = p.bp;
      r[WEL_BIT] = p.wel;
      return r;
   endfunction
endpackage

// File: rtl/blklock_region.sv
module blklock_region #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned PAGE_W = 6,
   parameter int unsigned CODE_W = 3
) (
   input  logic [CODE_W-1:0] code,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int unsigned NCODE = 1 << CODE_W;
   localparam int unsigned LIM_W = ADDR_W + 1;

   if (CODE_W < 3) begin : g_bad_code
      $error("blklock_region: CODE_W must be at least 3");
   end
   if (NCODE - 5 + PAGE_W >= ADDR_W - 2) begin : g_bad_page
      $error("blklock_region: page regions must stay below a quarter");
   end

   logic [LIM_W-1:0] lim [NCODE];

   for (genvar c = 0; c < NCODE; c++) begin : g_lim
      if (c == 0) begin : g_none
         assign lim[c] = '0;
      end else if (c == NCODE - 1) begin : g_all
         assign lim[c] = LIM_W'(1) << ADDR_W;
      end else if (c == NCODE - 2) begin : g_half
         assign lim[c] = LIM_W'(1) << (ADDR_W - 1);
      end else if (c == NCODE - 3) begin : g_quarter
         assign lim[c] = LIM_W'(1) << (ADDR_W - 2);
      end else begin : g_pages
         assign lim[c] = LIM_W'(1) << (PAGE_W + c - 1);
      end
   end

   assign hit = {1'b0, addr} < lim[code];
endmodule

// File: rtl/blklock_policy.sv
module blklock_policy
   import blklock_pkg::*;
(
   input  prot_t cur,
   input  prot_t nxt,
   input  logic  req,
   input  logic  reg_sel,
   input  logic  wp,
   input  logic  region_hit,
   output logic  ok,
   output logic  load_fields,
   output logic  load_wel
);
   logic fields_change;
   logic hw_lock;

   always_comb begin
      fields_change = (nxt.bp != cur.bp) || (nxt.hwen != cur.hwen);
      hw_lock       = wp && cur.hwen;
      if (reg_sel) begin
         ok = !fields_change || (cur.wel && !hw_lock);
      end else begin
         ok = cur.wel && !region_hit;
      end
      load_wel    = req && reg_sel && ok;
      load_fields = load_wel && fields_change;
   end
endmodule

// File: rtl/blklock_regs.sv
module blklock_regs
   import blklock_pkg::*;
#(
   parameter logic [BP_W-1:0] RST_BP   = '0,
   parameter logic            RST_HWEN = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  req,
   input  logic  ok,
   input  logic  load_fields,
   input  logic  load_wel,
   input  prot_t nxt,
   output prot_t cur,
   output logic  grant,
   output logic  reject
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur.hwen <= RST_HWEN;
         cur.bp   <= RST_BP;
         cur.wel  <= 1'b0;
         grant    <= 1'b0;
         reject   <= 1'b0;
      end else begin
         if (load_fields) begin
            cur.hwen <= nxt.hwen;
            cur.bp   <= nxt.bp;
         end
         if (load_wel) begin
            cur.wel <= nxt.wel;
         end
         grant  <= req && ok;
         reject <= req && !ok;
      end
   end
endmodule

// File: rtl/blklock_guard.sv
module blklock_guard
   import blklock_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned PAGE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              wr_reg_sel,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              wp_pin,
   output logic              grant,
   output logic              reject,
   output logic [7:0]        ctrl_reg
);
   prot_t cur;
   prot_t nxt;
   logic  hit;
   logic  ok;
   logic  ld_f;
   logic  ld_w;

   assign nxt.hwen = wr_data[HWEN_BIT];
   assign nxt.bp   = wr_data[BP_LSB +: BP_W];
   assign nxt.wel  = wr_data[WEL_BIT];

   blklock_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CODE_W(BP_W)) u_region (
      .code (cur.bp),
      .addr (wr_addr),
      .hit  (hit)
   );

   blklock_policy u_policy (
      .cur         (cur),
      .nxt         (nxt),
      .req         (wr_req),
      .reg_sel     (wr_reg_sel),
      .wp          (wp_pin),
      .region_hit  (hit),
      .ok          (ok),
      .load_fields (ld_f),
      .load_wel    (ld_w)
   );

   blklock_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (wr_req),
      .ok          (ok),
      .load_fields (ld_f),
      .load_wel    (ld_w),
      .nxt         (nxt),
      .cur         (cur),
      .grant       (grant),
      .reject      (reject)
   );

   assign ctrl_reg = pack_reg(cur);
endmodule

// File: rtl/blklock_guard_chk.sv
module blklock_guard_chk #(
   parameter int unsigned ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic              wr_reg_sel,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wp_pin,
   input logic              grant,
   input logic              reject,
   input logic [7:0]        ctrl_reg
);
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_reg[6:5] == 2'b00) && (ctrl_reg[0] == 1'b0));

   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> (grant != reject));

   a_r2_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_req |=> (!grant && !reject));

   a_r3_wel_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_reg_sel && !ctrl_reg[1]) |=> reject);

   a_r5_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_reg_sel && ctrl_reg[4:2] == 3'b111) |=> reject);

   a_r5_first_page: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_reg_sel && ctrl_reg[4:2] != 3'b000 && wr_addr < ADDR_W'(64)) |=> reject);

   a_r7_hw_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_pin && ctrl_reg[7]) |=> $stable(ctrl_reg[7:2]));

   a_r9_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> $stable(ctrl_reg));
endmodule

bind blklock_guard blklock_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_req     (wr_req),
   .wr_reg_sel (wr_reg_sel),
   .wr_addr    (wr_addr),
   .wp_pin     (wp_pin),
   .grant      (grant),
   .reject     (reject),
   .ctrl_reg   (ctrl_reg)
);

// File: tb/blklock_guard_bench.sv
module blklock_guard_bench;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_req = 1'b0;
   logic        wr_reg_sel = 1'b0;
   logic [14:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        wp_pin = 1'b0;
   logic        grant;
   logic        reject;
   logic [7:0]  ctrl_reg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blklock_guard u_blklock_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_req     (wr_req),
      .wr_reg_sel (wr_reg_sel),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wp_pin     (wp_pin),
      .grant      (grant),
      .reject     (reject),
      .ctrl_reg   (ctrl_reg)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int unsigned lim_of(int code);
      case (code)
         0: return 0;
         1: return 64;
         2: return 128;
         3: return 256;
         4: return 512;
         5: return 8192;
         6: return 16384;
         default: return 32768;
      endcase
   endfunction

   // one write; checks outcome, register value, and pulse width
   task automatic do_wr(string req, bit sel, int addr, logic [7:0] data,
                        bit exp_ok, logic [7:0] exp_reg);
      @(negedge clk);
      wr_req = 1'b1; wr_reg_sel = sel; wr_addr = 15'(addr); wr_data = data;
      @(negedge clk);
      wr_req = 1'b0;
      check({req, " grant"}, 32'(grant), 32'(exp_ok));
      check({req, " reject"}, 32'(reject), 32'(!exp_ok));
      check({req, " ctrl_reg"}, 32'(ctrl_reg), 32'(exp_reg));
      @(negedge clk);
      check("R2 pulse ends", 32'({grant, reject}), 32'h0);
   endtask

   task automatic t_reset();
      check("R1 ctrl_reg", 32'(ctrl_reg), 32'h00);
      check("R1 grant", 32'(grant), 32'h0);
      check("R1 reject", 32'(reject), 32'h0);
   endtask

   task automatic t_wel_clear();
      do_wr("R3 array no wel", 1'b0, 16'h0100, 8'h55, 1'b0, 8'h00);
      do_wr("R3 reg change no wel R9", 1'b1, 0, 8'h0C, 1'b0, 8'h00);
   endtask

   task automatic t_wel_set();
      do_wr("R4 set wel", 1'b1, 0, 8'h02, 1'b1, 8'h02);
      do_wr("R4 clear wel", 1'b1, 0, 8'h00, 1'b1, 8'h00);
      do_wr("R4 set wel again", 1'b1, 0, 8'h02, 1'b1, 8'h02);
   endtask

   task automatic t_regions();
      for (int c = 0; c < 8; c++) begin
         logic [7:0] v;
         int unsigned l;
         v = 8'((c << 2) | 2);
         l = lim_of(c);
         do_wr("R8 set code", 1'b1, 0, v, 1'b1, v);
         if (l > 0) do_wr("R5 last locked", 1'b0, int'(l) - 1, 8'hA5, 1'b0, v);
         if (l < 32768) do_wr("R6 first free", 1'b0, int'(l), 8'hA5, 1'b1, v);
         if (c < 7) do_wr("R6 top address", 1'b0, 32767, 8'h11, 1'b1, v);
         else do_wr("R5 whole array", 1'b0, 0, 8'h11, 1'b0, v);
      end
   endtask

   task automatic t_hw_lock();
      wp_pin = 1'b0;
      do_wr("R8 enable lock", 1'b1, 0, 8'h86, 1'b1, 8'h86);
      wp_pin = 1'b1;
      do_wr("R7 bp change R9", 1'b1, 0, 8'h8A, 1'b0, 8'h86);
      do_wr("R7 hwen clear R9", 1'b1, 0, 8'h06, 1'b0, 8'h86);
      do_wr("R4 wel clear under lock", 1'b1, 0, 8'h84, 1'b1, 8'h84);
      do_wr("R3 change no wel", 1'b1, 0, 8'h88, 1'b0, 8'h84);
      do_wr("R4 wel set under lock", 1'b1, 0, 8'h86, 1'b1, 8'h86);
      do_wr("R6 array outside", 1'b0, 64, 8'h01, 1'b1, 8'h86);
      do_wr("R5 array inside", 1'b0, 63, 8'h01, 1'b0, 8'h86);
      wp_pin = 1'b0;
      do_wr("R8 unlock change", 1'b1, 0, 8'h0A, 1'b1, 8'h0A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 idle", 32'({grant, reject}), 32'h0);
      t_wel_clear();
      t_wel_set();
      t_regions();
      t_hw_lock();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule